// File: doc/BRIEF.md
# Soft-Start and Output Fault Supervisor

This block sequences the start of a buck regulator and watches the output through digital comparator flags. It decides when the converter may run (`chip_enable`), when soft-start is over (`ss_done`), and when the output is healthy (`pgood`). While enabled it forces the low-side driver on when the output is too high. It latches a shutdown on undervoltage. On an overtemperature trip it stops the converter and restarts it once the die has cooled.

Four voltage flags reach the block: soft-start node above its completion level, output inside the power-good window, output over 120 %, and output under 75 % of the set point. Each one is qualified by a noise filter. The filter is a counter that needs `FILT_N` consecutive clock samples of a new level before that level takes effect, where `FILT_N = ceil(FILTER_NS / CLK_NS)`. The supply-UVLO flag and the two die-temperature flags are used without filtering. The soft-start filter is held cleared whenever the converter is disabled, so every start runs a complete soft-start.

Top module: `ssfault_sup`

## Requirements
- R1: While `rst` is high and in the cycle after it, all six outputs are low, whatever the inputs are.
- R2: `chip_enable` rises on the clock edge after `en` and `vcc_ok` are both high with `die_hot` low. If either of `en` or `vcc_ok` is low, the converter stays off.
- R3: A voltage flag takes effect on the `FILT_N`-th consecutive clock edge that samples its new level. A pulse that lasts `FILT_N-1` samples or fewer has no effect.
- R4: `ss_done` rises one edge after the filtered soft-start flag rises. The soft-start filter is cleared while the converter is off. As a result, from the edge that raises `chip_enable`, `ss_done` needs `FILT_N+1` further edges even if `ss_hi` is already high.
- R5: `pgood` is high exactly when `ss_done` is high and the filtered window flag is high.
- R6: `force_ldrv` follows the filtered over-voltage flag while `chip_enable` is high. It is not latched: it drops when the filtered flag drops.
- R7: The filtered undervoltage flag has no effect while soft-start is in progress. `chip_enable` stays high and `fault_uv` stays low.
- R8: After soft-start, a filtered undervoltage flag shuts the converter down on the next edge. `chip_enable` goes low and `fault_uv` goes high. This state holds while `en` and `vcc_ok` stay high, even after the output recovers.
- R9: `vcc_ok` low acts as a power-on reset from any state. On the next edge `chip_enable`, `fault_uv` and `fault_ot` are low.
- R10: `die_hot` high while enabled shuts the converter down and raises `fault_ot` on the next edge. The block waits until `die_cool` is high, then returns to off and restarts with a full soft-start.
- R11: `en` low clears a latched undervoltage fault and turns an active converter off on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable request |
| vcc_ok | input | 1 | Supply above the UVLO threshold |
| ss_hi | input | 1 | Soft-start node above its completion level (raw) |
| out_in_win | input | 1 | Output inside the ±10 % power-good window (raw) |
| out_over | input | 1 | Output above 120 % of the set point (raw) |
| out_under | input | 1 | Output below 75 % of the set point (raw) |
| die_hot | input | 1 | Die temperature at the trip level |
| die_cool | input | 1 | Die temperature below the restart level |
| chip_enable | output | 1 | Converter allowed to switch |
| ss_done | output | 1 | Soft-start complete |
| pgood | output | 1 | Power good |
| force_ldrv | output | 1 | Force the low-side driver on (soft crowbar) |
| fault_uv | output | 1 | Latched undervoltage shutdown |
| fault_ot | output | 1 | Overtemperature shutdown pending cool-down |

## Verification
The supervisor state appears at the ports through `chip_enable`, `ss_done`, `fault_uv` and `fault_ot`. A wrong state therefore shows on the edge after the transition that caused it. Filter counters that are off by one are only visible as timing: `force_ldrv` or `ss_done` moves one edge early or late. The bench measures those edges exactly and also sends pulses one sample shorter than the filter length. A soft-start filter that is not cleared on restart would let `ss_done` rise right after an undervoltage or overtemperature restart. The exact-latency check from a held-high `ss_hi` exposes that fault.

// File: rtl/ssfault_pkg.sv
package ssfault_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_SOFT    = 3'd1,
        ST_RUN     = 3'd2,
        ST_UVLATCH = 3'd3,
        ST_OTWAIT  = 3'd4
    } sup_state_t;

    // filtered voltage flags, one bit each
    typedef struct packed {
        logic ss;
        logic win;
        logic ov;
        logic uv;
    } vflags_t;

    localparam int NUM_VFLAGS = 4;

    // number of clock samples covering the filter time, at least one
    function automatic int filt_len(input int filter_ns, input int clk_ns);
        int n;
        n = (filter_ns + clk_ns - 1) / clk_ns;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic logic is_active(input sup_state_t s);
        return (s == ST_SOFT) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/ssfault_qual.sv
module ssfault_qual #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            filt <= raw;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ssfault_fsm.sv
module ssfault_fsm
    import ssfault_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       vcc_ok,
    input  logic       die_hot,
    input  logic       die_cool,
    input  logic       ss_f,
    input  logic       uv_f,
    output sup_state_t state
);
    sup_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (en && !die_hot) nxt = ST_SOFT;
            end
            ST_SOFT: begin
                if (!en)          nxt = ST_OFF;
                else if (die_hot) nxt = ST_OTWAIT;
                else if (ss_f)    nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!en)          nxt = ST_OFF;
                else if (die_hot) nxt = ST_OTWAIT;
                else if (uv_f)    nxt = ST_UVLATCH;
            end
            ST_UVLATCH: begin
                if (!en) nxt = ST_OFF;
            end
            ST_OTWAIT: begin
                if (die_cool) nxt = ST_OFF;
            end
            default: nxt = ST_OFF;
        endcase
        // supply loss overrides everything: power-on reset
        if (!vcc_ok) nxt = ST_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= nxt;
    end

endmodule

// File: rtl/ssfault_sup.sv
module ssfault_sup
    import ssfault_pkg::*;
#(
    parameter int CLK_NS    = 5,
    parameter int FILTER_NS = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic vcc_ok,
    input  logic ss_hi,
    input  logic out_in_win,
    input  logic out_over,
    input  logic out_under,
    input  logic die_hot,
    input  logic die_cool,
    output logic chip_enable,
    output logic ss_done,
    output logic pgood,
    output logic force_ldrv,
    output logic fault_uv,
    output logic fault_ot
);
    localparam int FILT_N = filt_len(FILTER_NS, CLK_NS);

    sup_state_t state;
    vflags_t    raw_v, filt_v, clr_v;
    logic       active;

    assign active = is_active(state);

    assign raw_v = '{ss: ss_hi, win: out_in_win, ov: out_over, uv: out_under};
    // only the soft-start qualifier restarts with the converter
    assign clr_v = '{ss: !active, win: 1'b0, ov: 1'b0, uv: 1'b0};

    for (genvar i = 0; i < NUM_VFLAGS; i++) begin : g_qual
        ssfault_qual #(.N(FILT_N)) u_qual (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr_v[i]),
            .raw  (raw_v[i]),
            .filt (filt_v[i])
        );
    end

    ssfault_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .vcc_ok   (vcc_ok),
        .die_hot  (die_hot),
        .die_cool (die_cool),
        .ss_f     (filt_v.ss),
        .uv_f     (filt_v.uv),
        .state    (state)
    );

    assign chip_enable = active;
    assign ss_done     = (state == ST_RUN);
    assign pgood       = ss_done && filt_v.win;
    assign force_ldrv  = active && filt_v.ov;
    assign fault_uv    = (state == ST_UVLATCH);
    assign fault_ot    = (state == ST_OTWAIT);

endmodule

// File: rtl/ssfault_chk.sv
module ssfault_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic vcc_ok,
    input logic die_hot,
    input logic chip_enable,
    input logic ss_done,
    input logic pgood,
    input logic force_ldrv,
    input logic fault_uv,
    input logic fault_ot
);
    // R5
    pgood_needs_ss_chk: assert property (@(posedge clk) disable iff (rst)
        pgood |-> ss_done);

    // R6
    force_only_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        force_ldrv |-> chip_enable);

    // R2
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(chip_enable) |-> $past(en && vcc_ok && !die_hot));

    // R8
    uv_latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_uv && en && vcc_ok) |=> fault_uv);

    // R9
    supply_por_chk: assert property (@(posedge clk) disable iff (rst)
        !vcc_ok |=> (!chip_enable && !fault_uv && !fault_ot));

    // R10
    ot_off_chk: assert property (@(posedge clk) disable iff (rst)
        fault_ot |-> !chip_enable);

    // R8
    single_fault_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fault_uv, fault_ot, chip_enable}));

endmodule

bind ssfault_sup ssfault_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .vcc_ok      (vcc_ok),
    .die_hot     (die_hot),
    .chip_enable (chip_enable),
    .ss_done     (ss_done),
    .pgood       (pgood),
    .force_ldrv  (force_ldrv),
    .fault_uv    (fault_uv),
    .fault_ot    (fault_ot)
);

// File: tb/sim_ssfault_sup.sv
module sim_ssfault_sup;
    localparam int CLK_NS = 5;
    localparam int FILT_NS = 20;
    localparam int N = 4;   // FILT_NS / CLK_NS

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, vcc_ok = 0, ss_hi = 0, out_in_win = 0;
    logic out_over = 0, out_under = 0, die_hot = 0, die_cool = 0;
    logic chip_enable, ss_done, pgood, force_ldrv, fault_uv, fault_ot;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ssfault_sup #(.CLK_NS(CLK_NS), .FILTER_NS(FILT_NS)) u0 (
        .clk(clk), .rst(rst), .en(en), .vcc_ok(vcc_ok), .ss_hi(ss_hi),
        .out_in_win(out_in_win), .out_over(out_over), .out_under(out_under),
        .die_hot(die_hot), .die_cool(die_cool), .chip_enable(chip_enable),
        .ss_done(ss_done), .pgood(pgood), .force_ldrv(force_ldrv),
        .fault_uv(fault_uv), .fault_ot(fault_ot)
    );

    // stimulus {en,vcc,ss,win,ov,uv,hot,cool}, wait, expected {ce,ssd,pg,frc,fuv,fot}
    typedef struct packed {
        logic [7:0] stim;
        logic [7:0] wt;
        logic [5:0] exp;
    } step_t;

    localparam int NSTEP = 18;
    localparam step_t TBL [NSTEP] = '{
        '{8'b0100_0000, 8'd10, 6'b000000},  // R2 no enable
        '{8'b1000_0000, 8'd10, 6'b000000},  // R2 no supply
        '{8'b1100_0000, 8'd10, 6'b100000},  // R2 soft-start running
        '{8'b1111_0000, 8'd10, 6'b111000},  // R4 R5 run, power good
        '{8'b1111_1000, 8'd10, 6'b111100},  // R6 crowbar on
        '{8'b1111_0000, 8'd10, 6'b111000},  // R6 crowbar released
        '{8'b1110_0000, 8'd10, 6'b110000},  // R5 window lost
        '{8'b1110_0100, 8'd10, 6'b000010},  // R8 uv latch
        '{8'b1110_0000, 8'd10, 6'b000010},  // R8 latch holds
        '{8'b0110_0000, 8'd10, 6'b000000},  // R11 enable low clears
        '{8'b1100_0100, 8'd10, 6'b100000},  // R7 uv ignored in soft-start
        '{8'b1110_0000, 8'd10, 6'b110000},  // R4 completes, uv gone
        '{8'b1110_0010, 8'd10, 6'b000001},  // R10 hot trip
        '{8'b1110_0000, 8'd10, 6'b000001},  // R10 waits for cool
        '{8'b1110_0001, 8'd10, 6'b110000},  // R10 restart
        '{8'b1010_0001, 8'd10, 6'b000000},  // R9 supply loss
        '{8'b1111_0001, 8'd12, 6'b111000},  // R9 restart after supply
        '{8'b0111_0001, 8'd10, 6'b000000}   // R11 enable low
    };

    function automatic logic [5:0] outs();
        return {chip_enable, ss_done, pgood, force_ldrv, fault_uv, fault_ot};
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] s);
        {en, vcc_ok, ss_hi, out_in_win, out_over, out_under, die_hot, die_cool} = s;
    endtask

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1 reset with active-looking inputs
        @(negedge clk);
        apply(8'b1111_1000);
        edges(3);
        check("R1 in reset", outs(), 6'b000000);
        apply(8'b0000_0000);
        rst = 1'b0;
        edges(1);
        check("R1 after reset", outs(), 6'b000000);

        for (int i = 0; i < NSTEP; i++) begin
            apply(TBL[i].stim);
            edges(int'(TBL[i].wt));
            check($sformatf("R2-table step %0d", i), outs(), TBL[i].exp);
        end

        // R4 exact soft-start latency with ss_hi already high
        apply(8'b0111_0000);
        edges(2);
        en = 1'b1;
        edges(1);
        check("R4 enable edge", outs(), 6'b100000);
        edges(N - 1);
        check("R4 before filter done", outs(), 6'b100000);
        edges(1);
        check("R4 filter done, ss_done next", outs(), 6'b100000);
        edges(1);
        check("R4 ss_done on N+1", outs(), 6'b111000);

        // R3 short over-voltage pulse ignored
        out_over = 1'b1;
        edges(N - 1);
        out_over = 1'b0;
        edges(N + 2);
        check("R3 short pulse", outs(), 6'b111000);

        // R3 R6 exact crowbar latency and release
        out_over = 1'b1;
        edges(N - 1);
        check("R3 ov before N", outs(), 6'b111000);
        edges(1);
        check("R6 ov at N", outs(), 6'b111100);
        out_over = 1'b0;
        edges(N - 1);
        check("R6 release before N", outs(), 6'b111100);
        edges(1);
        check("R6 release at N", outs(), 6'b111000);

        // R3 short undervoltage pulse ignored in run
        out_under = 1'b1;
        edges(N - 1);
        out_under = 1'b0;
        edges(N + 2);
        check("R3 short uv pulse", outs(), 6'b111000);

        // R8 exact shutdown edge
        out_under = 1'b1;
        edges(N);
        check("R8 uv filtered, still running", outs(), 6'b111000);
        edges(1);
        check("R8 latched next edge", outs(), 6'b000010);

        // R9 supply drop clears latch
        out_under = 1'b0;
        vcc_ok = 1'b0;
        edges(1);
        check("R9 por", outs(), 6'b000000);

        finish_run();
    end

endmodule